// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets a host fetch small, fixed configuration blobs by key. The host writes a 16-bit key into a write-only selector register, which picks one item from a small table built at elaboration. The host then performs read accesses on a data register. Each access returns the next bytes of the selected item and moves an internal cursor forward, so the host can read a whole item one access after another.

Reads can be 1, 2, 4 or 8 bytes wide. Bytes keep their memory order: the byte at the lowest offset lands in the lowest byte lane, as a memory copy would place it. The table holds two built-in items, a four-byte signature and a feature word, and two generic items whose keys and lengths are parameters. Any byte requested past the end of an item, or from a key that is not in the table, reads as zero. An access flagged as a write is accepted and then discarded.

When the port is mapped into I/O space, the data register sits at the selector address plus one. Address decoding is outside this block. Key bit 15 marks the architecture-specific bank and key bit 14 marks write mode. Both bits take part in the table match.

Top module: `cfgport_top`

## Requirements
- R1: After reset, rdValid and rdData are 0, the selected key is 0x0000 and the cursor is 0. A first read with no selector write returns the signature bytes.
- R2: A selector write picks the item whose key equals selKey and rewinds the cursor to 0. This holds even when the new key equals the current one.
- R3: A read access (dataAcc=1, dataWrite=0) with accSize codes 0, 1, 2, 3 reads 1, 2, 4 or 8 bytes. rdData and rdValid=1 appear on the clock edge after the access. Lanes above the access width are 0. rdValid is 0 after any cycle with no read access.
- R4: The byte at cursor offset k+j appears in rdData bits [8j+7:8j], with no byte swapping.
- R5: Each read moves the cursor forward by the access width, and the cursor stops at the item length. Lanes at or past the item length read 0x00. Item GEN_KEY holds GEN_LEN bytes with byte i = 0xA0+i. Item ARCH_KEY holds ARCH_LEN bytes with byte i = 0x5A XOR i.
- R6: Key 0x0000 is a 4-byte item holding 0x51, 0x45, 0x4D, 0x55 in that order.
- R7: Key 0x0001 is a 4-byte little-endian word. Bit 0 is always 1, bit 1 equals DMA_PRESENT, and all other bits are 0.
- R8: Keys are matched on all 16 bits, including bits 14 and 15. A key with no match behaves as an empty item, and every read of it returns 0.
- R9: An access with dataWrite=1 does not change the cursor. It leaves rdData unchanged and drives rdValid to 0 on the next edge.
- R10: When a selector write and a read access fall in the same cycle, the selector write takes effect first. The read returns bytes from offset 0 of the newly selected item.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selWrite | input | 1 | Selector register write strobe |
| selKey | input | 16 | Key written to the selector |
| dataAcc | input | 1 | Data register access strobe |
| dataWrite | input | 1 | Access is a write (discarded) |
| accSize | input | 2 | Access width code: 0=1, 1=2, 2=4, 3=8 bytes |
| rdData | output | 64 | Read bytes, lowest offset in lane 0 |
| rdValid | output | 1 | rdData holds the result of the previous cycle's read |

## Verification
The bench uses the default parameters: GEN_LEN=11, ARCH_LEN=5, GEN_KEY=0x0020, ARCH_KEY=0xC005 and DMA_PRESENT=1. An 11-byte item is not a multiple of 2, 4 or 8, so every access width meets a partial last read and then saturated reads past the end. The 5-byte item, which has bit 15 and bit 14 set in its key, does the same for the architecture bank. The sweep covers all four access widths against every table key and against near-miss keys that differ only in bit 14 or bit 15, with separate and same-cycle selector writes.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int OFF_W  = 8;
  localparam int LANES  = 8;
  localparam int NITEMS = 4;
  localparam int IDX_W  = $clog2(NITEMS);

  typedef struct packed {
    logic             fire;
    logic             hit;
    logic [IDX_W-1:0] item;
    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] len;
    logic [3:0]       nBytes;
  } fetch_t;

  // Content of item `item` at byte offset `off` (caller bounds off by length)
  function automatic logic [7:0] itemByte(input logic [IDX_W-1:0] item,
                                          input logic [OFF_W-1:0] off,
                                          input logic dmaBit);
    logic [7:0] b;
    case (item)
      2'd0: begin
        case (off[1:0])
          2'd0: b = 8'h51;
          2'd1: b = 8'h45;
          2'd2: b = 8'h4D;
          default: b = 8'h55;
        endcase
      end
      2'd1: b = (off == '0) ? {6'b0, dmaBit, 1'b1} : 8'h00;
      2'd2: b = 8'hA0 + off;
      default: b = 8'h5A ^ off;
    endcase
    return b;
  endfunction
endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter logic [15:0] GEN_KEY  = 16'h0020,
  parameter int          GEN_LEN  = 11,
  parameter logic [15:0] ARCH_KEY = 16'hC005,
  parameter int          ARCH_LEN = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selWrite,
  input  logic [15:0] selKey,
  input  logic        dataAcc,
  input  logic        dataWrite,
  input  logic [1:0]  accSize,
  output fetch_t      fetch
);
  logic [15:0]      keyTab [NITEMS];
  logic [OFF_W-1:0] lenTab [NITEMS];
  logic [NITEMS-1:0] hitVec;

  assign keyTab[0] = 16'h0000;
  assign keyTab[1] = 16'h0001;
  assign keyTab[2] = GEN_KEY;
  assign keyTab[3] = ARCH_KEY;
  assign lenTab[0] = OFF_W'(4);
  assign lenTab[1] = OFF_W'(4);
  assign lenTab[2] = OFF_W'(GEN_LEN);
  assign lenTab[3] = OFF_W'(ARCH_LEN);

  for (genvar g = 0; g < NITEMS; g++) begin : gKeyCmp
    assign hitVec[g] = (selKey == keyTab[g]);
  end

  logic [IDX_W-1:0] newIdx;
  always_comb begin
    newIdx = '0;
    for (int i = NITEMS - 1; i >= 0; i--)
      if (hitVec[i]) newIdx = IDX_W'(i);
  end

  logic [IDX_W-1:0] curIdx, effIdx;
  logic             curHit, effHit;
  logic [OFF_W-1:0] curOff, effOff, effLen, nextOff;
  logic [OFF_W:0]   sum;
  logic             rdFire;
  logic [3:0]       nBytes;

  assign effIdx  = selWrite ? newIdx : curIdx;
  assign effHit  = selWrite ? (|hitVec) : curHit;
  assign effOff  = selWrite ? '0 : curOff;
  assign effLen  = effHit ? lenTab[effIdx] : '0;
  assign rdFire  = dataAcc && !dataWrite;
  assign nBytes  = 4'd1 << accSize;
  assign sum     = {1'b0, effOff} + (OFF_W + 1)'(nBytes);
  assign nextOff = !rdFire ? effOff :
                   (sum > {1'b0, effLen}) ? effLen : sum[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx <= '0;
      curHit <= 1'b1;
      curOff <= '0;
    end else begin
      curIdx <= effIdx;
      curHit <= effHit;
      curOff <= nextOff;
    end
  end

  assign fetch.fire   = rdFire;
  assign fetch.hit    = effHit;
  assign fetch.item   = effIdx;
  assign fetch.off    = effOff;
  assign fetch.len    = effLen;
  assign fetch.nBytes = nBytes;
endmodule

// File: rtl/cfgport_dpath.sv
module cfgport_dpath
  import cfgport_pkg::*;
#(
  parameter bit DMA_PRESENT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  fetch_t      fetch,
  output logic [63:0] rdData,
  output logic        rdValid
);
  logic [8*LANES-1:0] nextData;

  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic [OFF_W:0] pos;
    logic           inItem;
    assign pos    = {1'b0, fetch.off} + (OFF_W + 1)'(l);
    assign inItem = fetch.hit && (4'(l) < fetch.nBytes) && (pos < {1'b0, fetch.len});
    assign nextData[8*l +: 8] = inItem ?
        itemByte(fetch.item, pos[OFF_W-1:0], DMA_PRESENT) : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= fetch.fire;
      if (fetch.fire) rdData <= nextData;
    end
  end
endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter logic [15:0] GEN_KEY     = 16'h0020,
  parameter int          GEN_LEN     = 11,
  parameter logic [15:0] ARCH_KEY    = 16'hC005,
  parameter int          ARCH_LEN    = 5,
  parameter bit          DMA_PRESENT = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        selWrite,
  input  logic [15:0] selKey,
  input  logic        dataAcc,
  input  logic        dataWrite,
  input  logic [1:0]  accSize,
  output logic [63:0] rdData,
  output logic        rdValid
);
  fetch_t fetch;

  cfgport_ctrl #(
    .GEN_KEY(GEN_KEY), .GEN_LEN(GEN_LEN),
    .ARCH_KEY(ARCH_KEY), .ARCH_LEN(ARCH_LEN)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .selWrite(selWrite), .selKey(selKey),
    .dataAcc(dataAcc), .dataWrite(dataWrite), .accSize(accSize),
    .fetch(fetch)
  );

  cfgport_dpath #(.DMA_PRESENT(DMA_PRESENT)) uDpath (
    .clk(clk), .rstN(rstN), .fetch(fetch),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/cfgport_check.sv
module cfgport_check #(
  parameter bit DMA_PRESENT = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic        selWrite,
  input logic [15:0] selKey,
  input logic        dataAcc,
  input logic        dataWrite,
  input logic [1:0]  accSize,
  input logic [63:0] rdData,
  input logic        rdValid
);
  a_r3_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !dataWrite) |=> rdValid);

  a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !dataAcc |=> !rdValid);

  a_r3_upper_lanes_zero: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !dataWrite && accSize == 2'd0) |=> (rdData[63:8] == 56'h0));

  a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && dataWrite) |=> (!rdValid && $stable(rdData)));

  a_r6_signature: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && selKey == 16'h0000 && dataAcc && !dataWrite && accSize == 2'd2)
      |=> (rdData[31:0] == 32'h554D4551));

  a_r7_feature: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && selKey == 16'h0001 && dataAcc && !dataWrite && accSize == 2'd2)
      |=> (rdData[31:0] == {30'h0, DMA_PRESENT, 1'b1}));

  a_r8_miss_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (selWrite && selKey == 16'h0002 && dataAcc && !dataWrite) |=> (rdData == 64'h0));
endmodule

bind cfgport_top cfgport_check #(.DMA_PRESENT(DMA_PRESENT)) uChk (
  .clk(clk), .rstN(rstN), .selWrite(selWrite), .selKey(selKey),
  .dataAcc(dataAcc), .dataWrite(dataWrite), .accSize(accSize),
  .rdData(rdData), .rdValid(rdValid)
);

// File: tb/cfgport_top_test.sv
module cfgport_top_test;
  localparam logic [15:0] GEN_KEY  = 16'h0020;
  localparam int          GEN_LEN  = 11;
  localparam logic [15:0] ARCH_KEY = 16'hC005;
  localparam int          ARCH_LEN = 5;
  localparam bit          DMA      = 1'b1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selWrite = 1'b0;
  logic [15:0] selKey = '0;
  logic        dataAcc = 1'b0;
  logic        dataWrite = 1'b0;
  logic [1:0]  accSize = '0;
  logic [63:0] rdData;
  logic        rdValid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [15:0] mKey;
  int          mOff;
  logic [63:0] lastData;

  always #10 clk = ~clk;

  cfgport_top #(
    .GEN_KEY(GEN_KEY), .GEN_LEN(GEN_LEN), .ARCH_KEY(ARCH_KEY),
    .ARCH_LEN(ARCH_LEN), .DMA_PRESENT(DMA)
  ) uut (
    .clk(clk), .rstN(rstN), .selWrite(selWrite), .selKey(selKey),
    .dataAcc(dataAcc), .dataWrite(dataWrite), .accSize(accSize),
    .rdData(rdData), .rdValid(rdValid)
  );

  function automatic int lenOf(input logic [15:0] k);
    if (k == 16'h0000 || k == 16'h0001) return 4;
    if (k == GEN_KEY) return GEN_LEN;
    if (k == ARCH_KEY) return ARCH_LEN;
    return 0;
  endfunction

  function automatic logic [7:0] expByte(input logic [15:0] k, input int off);
    logic [31:0] sig;
    logic [31:0] feat;
    sig  = 32'h554D4551;
    feat = {30'h0, DMA, 1'b1};
    if (off >= lenOf(k)) return 8'h00;
    if (k == 16'h0000) return sig[8*off +: 8];
    if (k == 16'h0001) return feat[8*off +: 8];
    if (k == GEN_KEY) return 8'(8'hA0 + off);
    return 8'(8'h5A ^ off);
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic selectKey(input logic [15:0] k);
    @(negedge clk);
    selWrite = 1'b1;
    selKey   = k;
    @(posedge clk);
    #1 selWrite = 1'b0;
    mKey = k;
    mOff = 0;
  endtask

  // One data access, optionally with a selector write in the same cycle
  task automatic access(input bit sel, input logic [15:0] k, input bit wr,
                        input logic [1:0] sz, input string tag);
    int n;
    logic [63:0] exp;
    @(negedge clk);
    selWrite  = sel;
    selKey    = k;
    dataAcc   = 1'b1;
    dataWrite = wr;
    accSize   = sz;
    @(posedge clk);
    #1;
    selWrite = 1'b0;
    dataAcc  = 1'b0;
    dataWrite = 1'b0;
    if (sel) begin
      mKey = k;
      mOff = 0;
    end
    if (wr) begin
      check({tag, " valid"}, {63'h0, rdValid}, 64'h0);
      check({tag, " data"}, rdData, lastData);
    end else begin
      n = 1 << sz;
      exp = '0;
      for (int j = 0; j < n; j++) exp[8*j +: 8] = expByte(mKey, mOff + j);
      check({tag, " valid"}, {63'h0, rdValid}, 64'h1);
      check({tag, " data"}, rdData, exp);
      mOff = (mOff + n > lenOf(mKey)) ? lenOf(mKey) : mOff + n;
      lastData = rdData;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] keys [9];
    keys = '{16'h0000, 16'h0001, GEN_KEY, ARCH_KEY, 16'h0002,
             16'h4000, 16'h8001, 16'h4020, 16'h8005};
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 rdValid", {63'h0, rdValid}, 64'h0);
    check("R1 rdData", rdData, 64'h0);
    rstN = 1'b1;
    mKey = 16'h0000;
    mOff = 0;
    lastData = '0;
    access(1'b0, 16'h0, 1'b0, 2'd2, "R1 default item");

    // R3/R4/R5/R6/R7/R8: sweep every key and width
    for (int k = 0; k < 9; k++) begin
      for (int s = 0; s < 4; s++) begin
        int n;
        string tag;
        tag = (keys[k] == 16'h0000) ? "R6" : (keys[k] == 16'h0001) ? "R7" :
              (lenOf(keys[k]) == 0) ? "R8" : "R5";
        selectKey(keys[k]);
        n = lenOf(keys[k]) / (1 << s) + 2;
        for (int r = 0; r < n; r++)
          access(1'b0, keys[k], 1'b0, 2'(s),
                 $sformatf("%s R3 R4 key %h size %0d", tag, keys[k], s));
      end
    end

    // R10: selector write and read in the same cycle
    for (int k = 0; k < 9; k++)
      for (int s = 0; s < 4; s++) begin
        access(1'b0, 16'h0, 1'b0, 2'd0, "R10 pre-read");
        access(1'b1, keys[k], 1'b0, 2'(s), $sformatf("R10 key %h", keys[k]));
      end

    // R2: reselecting the same key rewinds the cursor
    selectKey(GEN_KEY);
    access(1'b0, GEN_KEY, 1'b0, 2'd1, "R2 first");
    access(1'b0, GEN_KEY, 1'b0, 2'd0, "R2 advance");
    selectKey(GEN_KEY);
    access(1'b0, GEN_KEY, 1'b0, 2'd3, "R2 rewind");

    // R9: write accesses leave cursor and output untouched
    selectKey(ARCH_KEY);
    access(1'b0, ARCH_KEY, 1'b0, 2'd0, "R9 before");
    for (int w = 0; w < 4; w++)
      access(1'b0, ARCH_KEY, 1'b1, 2'(w), "R9 write");
    access(1'b0, ARCH_KEY, 1'b0, 2'd3, "R9 after");

    // R3: idle cycle drops rdValid
    @(negedge clk);
    @(negedge clk);
    check("R3 idle valid", {63'h0, rdValid}, 64'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule